// File: doc/BRIEF.md
# Serial EEPROM SPI Slave Front End

This block is the serial-side controller of a 512-byte nonvolatile memory. A host talks to it over a four-wire SPI link in mode 0. The block samples the data-in line on rising clock edges and updates the data-out line on falling clock edges. It decodes four commands: write-enable, status read, array read and array write. Read and write commands carry the ninth address bit inside the command byte, and an eight-bit byte address follows. The chip-select, serial clock and data-in lines are brought into a faster system clock through synchronisers. Every edge is detected in that clock domain.

Reads run without a break. The byte address counts upward after each byte and wraps from the top of the array to address zero. Writes need a prior write-enable and a high write-protect input. Accepted write bytes are gathered in an eight-byte page buffer. When chip-select rises on a byte boundary, a page engine commits them to the array and then holds a busy window of fixed length. While that window is open, only the status command is honoured. The array itself is an external synchronous RAM with one cycle of read latency. A static address range can be marked as protected, and no byte inside it is ever written.

Top module: `spi_eeprom_slave`

## Requirements
- R1: The data-out enable is low during reset and whenever chip-select has been high for more than the synchroniser delay. Data-out changes only after falling serial-clock edges.
- R2: The command byte 0000_A011 reads the array. A is address bit 8 and the next byte gives bits 7..0. Each byte is shifted out MSB first, starting on the falling edge after the last address bit.
- R3: During a read the address increments after each byte. After address 0x1FF the next byte comes from 0x000, within the same chip-select low period.
- R4: The command 0000_0110 sets the write-enable flag. The command 0000_0101 returns the status byte {6'b0, write-enable flag at bit 1, busy at bit 0}, and repeats it for as long as the clock keeps running.
- R5: The command 0000_A010 writes only if the write-enable flag is set and wp_n is high when chip-select rises. Otherwise the array is unchanged, busy does not rise and the write-enable flag keeps its value.
- R6: A write commits only when chip-select rises after at least one complete data byte and on a byte boundary. A partial final byte discards the whole write.
- R7: Successive write bytes advance only the low three address bits and wrap within the eight-byte page. A later byte to the same slot replaces an earlier one.
- R8: After an accepted write, busy reads 1 until the write window ends. The write-enable flag is then cleared. During that window every command except status read is ignored, and data-out stays low for the ignored transaction.
- R9: When prot_en is high, no byte whose address lies in [prot_lo, prot_hi] is written. The other bytes of the same page are written.
- R10: An unknown command byte makes the rest of the transaction ignored, with data-out low. The next chip-select fall decodes a new command normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_sck | input | 1 | Serial clock, mode 0 |
| spi_si | input | 1 | Serial data into the block |
| spi_so | output | 1 | Serial data out of the block |
| spi_so_oe | output | 1 | Output enable for spi_so |
| wp_n | input | 1 | Write protect, writes allowed when high |
| prot_en | input | 1 | Enables the protected address range |
| prot_lo | input | 9 | First protected address |
| prot_hi | input | 9 | Last protected address |
| mem_rd_addr | output | 9 | Array read address |
| mem_rd_data | input | 8 | Array read data, one cycle after address |
| mem_wr_en | output | 1 | Array write strobe |
| mem_wr_addr | output | 9 | Array write address |
| mem_wr_data | output | 8 | Array write data |

## Verification
The hardest state to reach from the pins is the busy window after a write, because commands must arrive while it is still open. The write window is long by default. Right after the committing chip-select rise, the stimulus issues a status read, then an array read, then a write-enable. It then polls status until busy drops, and checks that the enable flag was cleared and not set again. A second hard case is a chip-select rise in the middle of a byte. A bit-level driver task stops four bits into a data byte to produce it.

// File: rtl/eeprom_spi_pkg.sv
package eeprom_spi_pkg;
    localparam logic [7:0] CMD_WREN = 8'h06;
    localparam logic [7:0] CMD_RDSR = 8'h05;
    localparam logic [2:0] CMD_READ_LO  = 3'b011;
    localparam logic [2:0] CMD_WRITE_LO = 3'b010;

    typedef enum logic [2:0] {
        ST_IDLE, ST_OPC, ST_ADDR, ST_RDATA, ST_WDATA, ST_STAT, ST_SKIP
    } cmd_state_e;

    typedef enum logic [1:0] {
        PG_IDLE, PG_COMMIT, PG_WAIT
    } page_phase_e;
endpackage

// File: rtl/spi_in_sync.sv
module spi_in_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n_i,
    input  logic sck_i,
    input  logic si_i,
    output logic cs_n_o,
    output logic cs_fall,
    output logic cs_rise,
    output logic sck_rise,
    output logic sck_fall,
    output logic si_o
);
    logic [STAGES-1:0] cs_pipe_q, sck_pipe_q, si_pipe_q;
    logic              cs_prev_q, sck_prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_pipe_q  <= '1;
            sck_pipe_q <= '0;
            si_pipe_q  <= '0;
            cs_prev_q  <= 1'b1;
            sck_prev_q <= 1'b0;
        end else begin
            cs_pipe_q  <= {cs_pipe_q[STAGES-2:0], cs_n_i};
            sck_pipe_q <= {sck_pipe_q[STAGES-2:0], sck_i};
            si_pipe_q  <= {si_pipe_q[STAGES-2:0], si_i};
            cs_prev_q  <= cs_pipe_q[STAGES-1];
            sck_prev_q <= sck_pipe_q[STAGES-1];
        end
    end

    assign cs_n_o   = cs_pipe_q[STAGES-1];
    assign cs_fall  = cs_prev_q & ~cs_pipe_q[STAGES-1];
    assign cs_rise  = ~cs_prev_q & cs_pipe_q[STAGES-1];
    assign sck_rise = ~sck_prev_q & sck_pipe_q[STAGES-1];
    assign sck_fall = sck_prev_q & ~sck_pipe_q[STAGES-1];
    assign si_o     = si_pipe_q[STAGES-1];
endmodule

// File: rtl/eeprom_page_writer.sv
module eeprom_page_writer
    import eeprom_spi_pkg::*;
#(
    parameter int ADDR_W     = 9,
    parameter int DATA_W     = 8,
    parameter int PAGE_BYTES = 8,
    parameter int WR_CYCLES  = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              push,
    input  logic [ADDR_W-1:0] push_addr,
    input  logic [DATA_W-1:0] push_data,
    input  logic              start,
    input  logic              prot_en,
    input  logic [ADDR_W-1:0] prot_lo,
    input  logic [ADDR_W-1:0] prot_hi,
    output logic              busy,
    output logic              done,
    output logic              mem_wr_en,
    output logic [ADDR_W-1:0] mem_wr_addr,
    output logic [DATA_W-1:0] mem_wr_data
);
    localparam int PW = $clog2(PAGE_BYTES);
    localparam int CW = $clog2(WR_CYCLES + 1);

    typedef struct packed {
        page_phase_e                        phase;
        logic [PAGE_BYTES-1:0][DATA_W-1:0]  slots;
        logic [PAGE_BYTES-1:0]              vld;
        logic [ADDR_W-PW-1:0]               page;
        logic [PW-1:0]                      idx;
        logic [CW-1:0]                      cnt;
        logic                               wr_en;
        logic [ADDR_W-1:0]                  wr_addr;
        logic [DATA_W-1:0]                  wr_data;
        logic                               done;
    } pg_t;

    pg_t pg_d, pg_q;
    logic [ADDR_W-1:0] slot_addr;
    logic              slot_locked;

    assign slot_addr   = {pg_q.page, pg_q.idx};
    assign slot_locked = prot_en && (slot_addr >= prot_lo) && (slot_addr <= prot_hi);

    always_comb begin
        pg_d       = pg_q;
        pg_d.wr_en = 1'b0;
        pg_d.done  = 1'b0;
        unique case (pg_q.phase)
            PG_IDLE: begin
                if (clear) pg_d.vld = '0;
                if (push) begin
                    pg_d.slots[push_addr[PW-1:0]] = push_data;
                    pg_d.vld[push_addr[PW-1:0]]   = 1'b1;
                    pg_d.page = push_addr[ADDR_W-1:PW];
                end
                if (start && |pg_q.vld) begin
                    pg_d.phase = PG_COMMIT;
                    pg_d.idx   = '0;
                end
            end
            PG_COMMIT: begin
                if (pg_q.vld[pg_q.idx] && !slot_locked) begin
                    pg_d.wr_en   = 1'b1;
                    pg_d.wr_addr = slot_addr;
                    pg_d.wr_data = pg_q.slots[pg_q.idx];
                end
                if (pg_q.idx == PW'(PAGE_BYTES - 1)) begin
                    pg_d.phase = PG_WAIT;
                    pg_d.cnt   = '0;
                end else begin
                    pg_d.idx = pg_q.idx + 1'b1;
                end
            end
            PG_WAIT: begin
                if (pg_q.cnt == CW'(WR_CYCLES - 1)) begin
                    pg_d.phase = PG_IDLE;
                    pg_d.done  = 1'b1;
                    pg_d.vld   = '0;
                end else begin
                    pg_d.cnt = pg_q.cnt + 1'b1;
                end
            end
            default: pg_d.phase = PG_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pg_q       <= '0;
            pg_q.phase <= PG_IDLE;
        end else begin
            pg_q <= pg_d;
        end
    end

    assign busy        = (pg_q.phase != PG_IDLE);
    assign done        = pg_q.done;
    assign mem_wr_en   = pg_q.wr_en;
    assign mem_wr_addr = pg_q.wr_addr;
    assign mem_wr_data = pg_q.wr_data;
endmodule

// File: rtl/spi_eeprom_slave.sv
module spi_eeprom_slave
    import eeprom_spi_pkg::*;
#(
    parameter int ADDR_W      = 9,
    parameter int PAGE_BYTES  = 8,
    parameter int WR_CYCLES   = 1000,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_cs_n,
    input  logic              spi_sck,
    input  logic              spi_si,
    output logic              spi_so,
    output logic              spi_so_oe,
    input  logic              wp_n,
    input  logic              prot_en,
    input  logic [ADDR_W-1:0] prot_lo,
    input  logic [ADDR_W-1:0] prot_hi,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic [7:0]        mem_rd_data,
    output logic              mem_wr_en,
    output logic [ADDR_W-1:0] mem_wr_addr,
    output logic [7:0]        mem_wr_data
);
    localparam int PW = $clog2(PAGE_BYTES);

    typedef struct packed {
        cmd_state_e        state;
        logic [2:0]        bcnt;
        logic [7:0]        sh;
        logic [7:0]        tx;
        logic [ADDR_W-1:0] addr;
        logic              is_wr;
        logic              got_byte;
        logic              wel;
        logic              so;
    } cmd_t;

    cmd_t cmd_d, cmd_q;

    logic cs_n_s, cs_fall, cs_rise, sck_rise, sck_fall, si_s;
    logic wr_busy, wr_done;
    logic wb_clear, wb_push, wb_start;
    logic [7:0] rx_byte, load_byte, status_byte;
    logic wel_flag;

    spi_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .cs_n_i(spi_cs_n), .sck_i(spi_sck), .si_i(spi_si),
        .cs_n_o(cs_n_s), .cs_fall(cs_fall), .cs_rise(cs_rise),
        .sck_rise(sck_rise), .sck_fall(sck_fall), .si_o(si_s)
    );

    eeprom_page_writer #(
        .ADDR_W(ADDR_W), .DATA_W(8), .PAGE_BYTES(PAGE_BYTES), .WR_CYCLES(WR_CYCLES)
    ) u_page (
        .clk(clk), .rst_n(rst_n),
        .clear(wb_clear), .push(wb_push), .push_addr(cmd_q.addr), .push_data(rx_byte),
        .start(wb_start), .prot_en(prot_en), .prot_lo(prot_lo), .prot_hi(prot_hi),
        .busy(wr_busy), .done(wr_done),
        .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data)
    );

    assign rx_byte     = {cmd_q.sh[6:0], si_s};
    assign status_byte = {6'b0, cmd_q.wel, wr_busy};
    assign load_byte   = (cmd_q.state == ST_RDATA) ? mem_rd_data : status_byte;

    always_comb begin
        cmd_d    = cmd_q;
        wb_clear = 1'b0;
        wb_push  = 1'b0;
        wb_start = 1'b0;
        if (wr_done) cmd_d.wel = 1'b0;
        if (cs_rise) begin
            if (cmd_q.state == ST_WDATA && cmd_q.bcnt == 3'd0 && cmd_q.got_byte
                && cmd_q.wel && wp_n)
                wb_start = 1'b1;
            cmd_d.state = ST_IDLE;
            cmd_d.so    = 1'b0;
        end else if (cs_fall) begin
            cmd_d.state    = ST_OPC;
            cmd_d.bcnt     = 3'd0;
            cmd_d.got_byte = 1'b0;
            cmd_d.so       = 1'b0;
        end else if (!cs_n_s) begin
            if (sck_rise) begin
                cmd_d.sh   = rx_byte;
                cmd_d.bcnt = cmd_q.bcnt + 3'd1;
                if (cmd_q.bcnt == 3'd7) begin
                    unique case (cmd_q.state)
                        ST_OPC: begin
                            if (wr_busy) begin
                                cmd_d.state = (rx_byte == CMD_RDSR) ? ST_STAT : ST_SKIP;
                            end else if (rx_byte == CMD_RDSR) begin
                                cmd_d.state = ST_STAT;
                            end else if (rx_byte == CMD_WREN) begin
                                cmd_d.wel   = 1'b1;
                                cmd_d.state = ST_SKIP;
                            end else if (rx_byte[7:4] == 4'b0 &&
                                         (rx_byte[2:0] == CMD_READ_LO ||
                                          rx_byte[2:0] == CMD_WRITE_LO)) begin
                                cmd_d.is_wr          = (rx_byte[2:0] == CMD_WRITE_LO);
                                cmd_d.addr[ADDR_W-1] = rx_byte[3];
                                cmd_d.state          = ST_ADDR;
                                wb_clear             = (rx_byte[2:0] == CMD_WRITE_LO);
                            end else begin
                                cmd_d.state = ST_SKIP;
                            end
                        end
                        ST_ADDR: begin
                            cmd_d.addr[7:0] = rx_byte;
                            cmd_d.state     = cmd_q.is_wr ? ST_WDATA : ST_RDATA;
                        end
                        ST_WDATA: begin
                            wb_push        = 1'b1;
                            cmd_d.got_byte = 1'b1;
                            cmd_d.addr     = {cmd_q.addr[ADDR_W-1:PW],
                                              cmd_q.addr[PW-1:0] + 1'b1};
                        end
                        default: ;
                    endcase
                end
            end
            if (sck_fall && (cmd_q.state == ST_RDATA || cmd_q.state == ST_STAT)) begin
                if (cmd_q.bcnt == 3'd0) begin
                    cmd_d.so = load_byte[7];
                    cmd_d.tx = {load_byte[6:0], 1'b0};
                    if (cmd_q.state == ST_RDATA) cmd_d.addr = cmd_q.addr + 1'b1;
                end else begin
                    cmd_d.so = cmd_q.tx[7];
                    cmd_d.tx = {cmd_q.tx[6:0], 1'b0};
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q       <= '0;
            cmd_q.state <= ST_IDLE;
        end else begin
            cmd_q <= cmd_d;
        end
    end

    assign wel_flag    = cmd_q.wel;
    assign spi_so      = cmd_q.so;
    assign spi_so_oe   = (cmd_q.state != ST_IDLE);
    assign mem_rd_addr = cmd_q.addr;
endmodule

// File: rtl/eeprom_spi_checker.sv
module eeprom_spi_checker #(
    parameter int ADDR_W = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic              spi_cs_n,
    input logic              spi_so_oe,
    input logic              prot_en,
    input logic [ADDR_W-1:0] prot_lo,
    input logic [ADDR_W-1:0] prot_hi,
    input logic              mem_wr_en,
    input logic [ADDR_W-1:0] mem_wr_addr,
    input logic              wr_busy,
    input logic              wel_flag,
    input logic              cs_rise
);
    // R1
    oe_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_cs_n && $past(spi_cs_n) && $past(spi_cs_n, 2) && $past(spi_cs_n, 3))
        |-> !spi_so_oe);

    // R9
    protected_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> !(prot_en && mem_wr_addr >= prot_lo && mem_wr_addr <= prot_hi));

    // R7
    same_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_en && $past(mem_wr_en)) |-> (mem_wr_addr[ADDR_W-1:3] == $past(mem_wr_addr[ADDR_W-1:3])));

    // R6
    start_on_deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_busy) |-> $past(cs_rise));

    // R5
    start_needs_wel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_busy) |-> wel_flag);

    // R8
    wel_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wr_busy) |=> !wel_flag);

    // R8
    write_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> wr_busy);
endmodule

bind spi_eeprom_slave eeprom_spi_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .spi_so_oe(spi_so_oe),
    .prot_en(prot_en), .prot_lo(prot_lo), .prot_hi(prot_hi),
    .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr),
    .wr_busy(wr_busy), .wel_flag(wel_flag), .cs_rise(cs_rise)
);

// File: tb/spi_eeprom_slave_test.sv
module spi_eeprom_slave_test;
    localparam int H = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1, sck = 1'b0, si = 1'b0;
    logic       so, so_oe;
    logic       wp_n = 1'b1, prot_en = 1'b0;
    logic [8:0] prot_lo = '0, prot_hi = '0;
    logic [8:0] rd_addr, wr_addr;
    logic [7:0] rd_data, wr_data;
    logic       wr_en;

    logic [7:0] ram [512];
    logic [7:0] model [512];

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    string      tag_q[$];
    logic [7:0] exp_q[$];
    logic [7:0] act_q[$];

    always #4 clk = ~clk;

    spi_eeprom_slave uut (
        .clk(clk), .rst_n(rst_n), .spi_cs_n(cs_n), .spi_sck(sck), .spi_si(si),
        .spi_so(so), .spi_so_oe(so_oe), .wp_n(wp_n), .prot_en(prot_en),
        .prot_lo(prot_lo), .prot_hi(prot_hi), .mem_rd_addr(rd_addr),
        .mem_rd_data(rd_data), .mem_wr_en(wr_en), .mem_wr_addr(wr_addr),
        .mem_wr_data(wr_data)
    );

    always @(posedge clk) begin
        if (wr_en) ram[wr_addr] <= wr_data;
        rd_data <= ram[rd_addr];
    end

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    // scoreboard monitor
    initial begin
        forever begin
            @(negedge clk);
            while (exp_q.size() > 0 && act_q.size() > 0)
                check(tag_q.pop_front(), act_q.pop_front(), exp_q.pop_front());
        end
    end

    task automatic expect_byte(input string tag, input logic [7:0] v);
        tag_q.push_back(tag);
        exp_q.push_back(v);
    endtask

    task automatic spi_bits(input logic [7:0] tx, input int n, output logic [7:0] rx);
        rx = '0;
        for (int i = 7; i > 7 - n; i--) begin
            si = tx[i];
            repeat (H) @(negedge clk);
            rx[i] = so;
            sck = 1'b1;
            repeat (H) @(negedge clk);
            sck = 1'b0;
        end
    endtask

    task automatic spi_byte(input logic [7:0] tx, output logic [7:0] rx);
        spi_bits(tx, 8, rx);
    endtask

    task automatic cs_begin();
        cs_n = 1'b0;
        repeat (H) @(negedge clk);
    endtask

    task automatic cs_end();
        cs_n = 1'b1;
        repeat (3 * H) @(negedge clk);
    endtask

    task automatic get_status(output logic [7:0] st);
        logic [7:0] rx;
        cs_begin();
        spi_byte(8'h05, rx);
        spi_byte(8'h00, st);
        cs_end();
    endtask

    task automatic status_is(input string tag, input logic [7:0] v);
        logic [7:0] st;
        expect_byte(tag, v);
        get_status(st);
        act_q.push_back(st);
    endtask

    task automatic do_read(input string tag, input logic [8:0] a, input int n);
        logic [7:0] rx;
        cs_begin();
        spi_byte({4'b0, a[8], 3'b011}, rx);
        spi_byte(a[7:0], rx);
        for (int k = 0; k < n; k++) begin
            expect_byte(tag, model[9'(a + k)]);
            spi_byte(8'h00, rx);
            act_q.push_back(rx);
        end
        cs_end();
    endtask

    task automatic do_wren();
        logic [7:0] rx;
        cs_begin();
        spi_byte(8'h06, rx);
        cs_end();
    endtask

    task automatic do_write(input logic [8:0] a, input int n, input logic [7:0] seed, input bit upd);
        logic [7:0] rx, d;
        logic [8:0] slot;
        cs_begin();
        spi_byte({4'b0, a[8], 3'b010}, rx);
        spi_byte(a[7:0], rx);
        for (int k = 0; k < n; k++) begin
            d = seed + 8'(k * 29);
            slot = {a[8:3], 3'(a[2:0] + k)};
            spi_byte(d, rx);
            if (upd && !(prot_en && slot >= prot_lo && slot <= prot_hi))
                model[slot] = d;
        end
        cs_end();
    endtask

    task automatic wait_idle();
        logic [7:0] st;
        for (int t = 0; t < 50; t++) begin
            get_status(st);
            if (st[0] == 1'b0) break;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] rx, oe_b;
        for (int i = 0; i < 512; i++) begin
            ram[i]   = 8'(i * 7 + 3);
            model[i] = 8'(i * 7 + 3);
        end
        repeat (10) @(negedge clk);
        // R1 reset state
        check("R1 reset oe", {7'b0, so_oe}, 8'h00);
        check("R1 reset so", {7'b0, so}, 8'h00);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R4 initial status
        status_is("R4 status after reset", 8'h00);
        // R2 read with A8=0
        do_read("R2 read 0x005", 9'h005, 3);
        // R3 wrap across top, A8=1
        do_read("R3 wrap read 0x1FE", 9'h1FE, 4);

        // R5 write without enable ignored
        do_write(9'h040, 2, 8'h11, 1'b0);
        status_is("R5 no busy without enable", 8'h00);
        do_read("R5 unchanged after unenabled write", 9'h040, 2);

        // R4 enable flag
        do_wren();
        status_is("R4 status after enable", 8'h02);

        // R5 write with wp_n low ignored
        wp_n = 1'b0;
        do_write(9'h050, 2, 8'h22, 1'b0);
        wp_n = 1'b1;
        status_is("R5 wp low keeps flag, no busy", 8'h02);
        do_read("R5 unchanged after protected-pin write", 9'h050, 2);

        // R6 partial byte aborts
        cs_begin();
        spi_byte(8'h02, rx);
        spi_byte(8'h60, rx);
        spi_byte(8'h5A, rx);
        spi_bits(8'hC3, 4, rx);
        cs_end();
        status_is("R6 partial byte no busy", 8'h02);
        do_read("R6 unchanged after partial write", 9'h060, 2);

        // R8 busy window
        do_write(9'h0A3, 3, 8'h37, 1'b1);
        status_is("R8 busy and flag during write", 8'h03);
        cs_begin();
        spi_byte(8'h03, rx);
        spi_byte(8'hA3, rx);
        spi_byte(8'h00, rx);
        check("R8 oe during ignored read", {7'b0, so_oe}, 8'h01);
        cs_end();
        check("R8 read during busy ignored", rx, 8'h00);
        do_wren();
        wait_idle();
        status_is("R8 flag cleared after write", 8'h00);
        do_read("R8 written data", 9'h0A3, 3);

        // R7 page wrap with overwrite
        do_wren();
        do_write(9'h0FE, 10, 8'h90, 1'b1);
        wait_idle();
        do_read("R7 page wrap", 9'h0F8, 8);

        // R9 protected range
        prot_en = 1'b1;
        prot_lo = 9'h13A;
        prot_hi = 9'h13F;
        do_wren();
        do_write(9'h138, 4, 8'h4C, 1'b1);
        wait_idle();
        do_read("R9 protected range", 9'h138, 4);
        prot_en = 1'b0;

        // R10 unknown opcode
        cs_begin();
        spi_byte(8'hFF, rx);
        spi_byte(8'h03, rx);
        check("R10 unknown op so low", rx, 8'h00);
        spi_byte(8'h00, rx);
        spi_byte(8'h00, rx);
        check("R10 unknown op later byte", rx, 8'h00);
        cs_end();
        status_is("R10 recovery after unknown op", 8'h00);
        // R1 released after deselect
        check("R1 oe after deselect", {7'b0, so_oe}, 8'h00);

        repeat (20) @(negedge clk);
        if (exp_q.size() != act_q.size()) begin
            checks++;
            fails++;
            $display("FAIL scoreboard actual=%0d expected=%0d", act_q.size(), exp_q.size());
        end
        oe_b = 8'h00;
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails + int'(oe_b));
        $finish;
    end
endmodule